// File: doc/BRIEF.md
# Exception Entry Sequencer

This block computes, in a single clock, every control-register update a processor core makes when it takes an exception or interrupt. The core presents a cause code with a valid strobe, together with the current program counter, status word, exception register, TLB flag word and the faulting data address. One clock later the block returns the next values of status, saved status, break status, exception register, exception return address, break return address, TLB flags, bad-address register and program counter. Each value comes with a one-cycle write-enable pulse that the register file uses to commit it.

The cause code selects a class: hardware interrupt, TLB miss, page-permission fault, general fault (supervisor-only access, illegal instruction, trap), break, or misaligned access. Together with the exception-handling bit of the incoming status word, the class decides which save registers are written, which vector is taken, and how the double-miss and write flags of the TLB flag word move. An unknown cause raises an error pulse and commits nothing.

Top module: `exc_entry_seq`

## Requirements
- R1: On a taken cause, the new status equals the old status with bit 0 (interrupt enable of the previous context) and bit 1 (user mode) cleared and one handler bit set: bit 3 for an interrupt, bit 2 (exception-handling, EH) for every other cause.
- R2: On a taken cause other than misaligned, the new exception register holds the 5-bit cause code in bits [6:2] with every other bit copied from the old value.
- R3: An interrupt (code 2) writes the old status to saved status, PC+4 to the exception return address, and the general vector to the PC.
- R4: A TLB miss (code 12) with EH clear writes saved status and PC+4, clears the double-miss flag (bit 3 of the TLB flag word), sets the write flag (bit 18), and jumps to the fast-miss vector.
- R5: A TLB miss with EH set sets the double-miss flag, leaves saved status and return address unwritten, and jumps to the general vector.
- R6: Execute, read and write permission faults (codes 13, 14, 15) write saved status and PC+4 and jump to the general vector without touching the TLB flag word.
- R7: Trap (3), illegal instruction (5) and supervisor-only faults (9, 10, 11) write saved status and PC+4 only when EH was clear, and always jump to the general vector.
- R8: A break (code 1) writes break status and PC+4 into the break return address only when EH was clear, never writes saved status or the exception return address, and jumps to the general vector.
- R9: A misaligned access (code 6) loads the fault address into the bad-address register, replaces the whole exception register with the cause code shifted left by two, saves like R7, and jumps to the general vector.
- R10: Any other code raises the unhandled-cause error for one cycle and asserts no write enable.
- R11: Outputs appear exactly one clock after the valid cycle; write enables are single-cycle pulses and stay low in cycles without valid, including right after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| excValid | input | 1 | An exception is taken this cycle |
| excCause | input | 5 | Cause code |
| curPc | input | 32 | Address of the excepting instruction |
| curStatus | input | 32 | Current status word |
| curExcReg | input | 32 | Current exception register |
| curTlbMisc | input | 32 | Current TLB flag word |
| faultAddr | input | 32 | Faulting data address |
| statusWe | output | 1 | Status write pulse |
| nextStatus | output | 32 | New status |
| estatusWe | output | 1 | Saved-status write pulse |
| nextEstatus | output | 32 | New saved status |
| bstatusWe | output | 1 | Break-status write pulse |
| nextBstatus | output | 32 | New break status |
| excRegWe | output | 1 | Exception register write pulse |
| nextExcReg | output | 32 | New exception register |
| eaWe | output | 1 | Exception return address write pulse |
| nextEa | output | 32 | New exception return address |
| baWe | output | 1 | Break return address write pulse |
| nextBa | output | 32 | New break return address |
| tlbMiscWe | output | 1 | TLB flag word write pulse |
| nextTlbMisc | output | 32 | New TLB flag word |
| badAddrWe | output | 1 | Bad-address write pulse |
| nextBadAddr | output | 32 | New bad address |
| pcWe | output | 1 | PC write pulse |
| nextPc | output | 32 | Handler entry address |
| unhandledErr | output | 1 | Unknown cause pulse |

## Verification
A wrong class decode or a mis-sampled EH bit shows one clock after the valid cycle as a wrong write-enable pattern or a wrong vector on the PC output. A corrupted save decision is visible in the same cycle as a missing or extra saved-status, break-status or return-address pulse. The bench sweeps all 32 codes against both EH values and three operand patterns, so every class and both EH branches appear, and it checks the cycle after each entry for stray pulses.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;

  typedef enum logic [2:0] {
    CL_NONE, CL_IRQ, CL_TLBMISS, CL_PERM, CL_FAULT, CL_BREAK, CL_ALIGN
  } exc_class_t;

  // Strobes from control to datapath.
  typedef struct packed {
    logic taken;     // a known cause was accepted
    logic bad;       // unknown cause
    logic useIh;     // set interrupt handler bit rather than EH
    logic saveE;     // write saved status and exception return address
    logic saveB;     // write break status and break return address
    logic fastVec;   // take the fast-miss vector
    logic tlbTouch;  // write the TLB flag word
    logic tlbDbl;    // double miss: set the double-miss flag
    logic excFull;   // replace the whole exception register
    logic loadBad;   // load the bad-address register
  } exc_strobe_t;

endpackage

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
  import exc_entry_pkg::*;
#(
  parameter int CAUSE_W     = 5,
  parameter int CODE_BREAK  = 1,
  parameter int CODE_IRQ    = 2,
  parameter int CODE_TRAP   = 3,
  parameter int CODE_ILL    = 5,
  parameter int CODE_ALIGN  = 6,
  parameter int CODE_SUPA   = 9,
  parameter int CODE_SUPI   = 10,
  parameter int CODE_SUPD   = 11,
  parameter int CODE_TLBM   = 12,
  parameter int CODE_PERMX  = 13,
  parameter int CODE_PERMR  = 14,
  parameter int CODE_PERMW  = 15
) (
  input  logic               excValid,
  input  logic [CAUSE_W-1:0] excCause,
  input  logic               ehIn,
  output exc_strobe_t        strobes
);

  exc_class_t cls;

  always_comb begin
    cls = CL_NONE;
    if (excCause == CAUSE_W'(CODE_IRQ))        cls = CL_IRQ;
    else if (excCause == CAUSE_W'(CODE_TLBM))  cls = CL_TLBMISS;
    else if (excCause == CAUSE_W'(CODE_PERMX) || excCause == CAUSE_W'(CODE_PERMR) ||
             excCause == CAUSE_W'(CODE_PERMW)) cls = CL_PERM;
    else if (excCause == CAUSE_W'(CODE_TRAP) || excCause == CAUSE_W'(CODE_ILL) ||
             excCause == CAUSE_W'(CODE_SUPA) || excCause == CAUSE_W'(CODE_SUPI) ||
             excCause == CAUSE_W'(CODE_SUPD))  cls = CL_FAULT;
    else if (excCause == CAUSE_W'(CODE_BREAK)) cls = CL_BREAK;
    else if (excCause == CAUSE_W'(CODE_ALIGN)) cls = CL_ALIGN;
  end

  always_comb begin
    strobes = '0;
    if (excValid) begin
      unique case (cls)
        CL_IRQ: begin
          strobes.taken = 1'b1;
          strobes.useIh = 1'b1;
          strobes.saveE = 1'b1;
        end
        CL_TLBMISS: begin
          strobes.taken    = 1'b1;
          strobes.tlbTouch = 1'b1;
          strobes.saveE    = !ehIn;
          strobes.fastVec  = !ehIn;
          strobes.tlbDbl   = ehIn;
        end
        CL_PERM: begin
          strobes.taken = 1'b1;
          strobes.saveE = 1'b1;
        end
        CL_FAULT: begin
          strobes.taken = 1'b1;
          strobes.saveE = !ehIn;
        end
        CL_BREAK: begin
          strobes.taken = 1'b1;
          strobes.saveB = !ehIn;
        end
        CL_ALIGN: begin
          strobes.taken   = 1'b1;
          strobes.saveE   = !ehIn;
          strobes.excFull = 1'b1;
          strobes.loadBad = 1'b1;
        end
        default: strobes.bad = 1'b1;
      endcase
    end
  end

  // R8: break saves never coexist with exception saves
  always_comb begin
    p_save_excl_r8: assert (!(strobes.saveE && strobes.saveB));
  end

endmodule

// File: rtl/exc_entry_dp.sv
module exc_entry_dp
  import exc_entry_pkg::*;
#(
  parameter int          XLEN     = 32,
  parameter int          CAUSE_W  = 5,
  parameter int          PIE_BIT  = 0,
  parameter int          U_BIT    = 1,
  parameter int          EH_BIT   = 2,
  parameter int          IH_BIT   = 3,
  parameter int          DBL_BIT  = 3,
  parameter int          WR_BIT   = 18,
  parameter int          CAUSE_LSB = 2,
  parameter logic [31:0] GEN_VEC  = 32'h0000_0020,
  parameter logic [31:0] FAST_VEC = 32'h0000_0100
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               excValid,
  input  exc_strobe_t        strobes,
  input  logic [CAUSE_W-1:0] excCause,
  input  logic [XLEN-1:0]    curPc,
  input  logic [XLEN-1:0]    curStatus,
  input  logic [XLEN-1:0]    curExcReg,
  input  logic [XLEN-1:0]    curTlbMisc,
  input  logic [XLEN-1:0]    faultAddr,
  output logic               statusWe,
  output logic [XLEN-1:0]    nextStatus,
  output logic               estatusWe,
  output logic [XLEN-1:0]    nextEstatus,
  output logic               bstatusWe,
  output logic [XLEN-1:0]    nextBstatus,
  output logic               excRegWe,
  output logic [XLEN-1:0]    nextExcReg,
  output logic               eaWe,
  output logic [XLEN-1:0]    nextEa,
  output logic               baWe,
  output logic [XLEN-1:0]    nextBa,
  output logic               tlbMiscWe,
  output logic [XLEN-1:0]    nextTlbMisc,
  output logic               badAddrWe,
  output logic [XLEN-1:0]    nextBadAddr,
  output logic               pcWe,
  output logic [XLEN-1:0]    nextPc,
  output logic               unhandledErr
);

  localparam logic [XLEN-1:0] PIE_M   = XLEN'(1) << PIE_BIT;
  localparam logic [XLEN-1:0] U_M     = XLEN'(1) << U_BIT;
  localparam logic [XLEN-1:0] EH_M    = XLEN'(1) << EH_BIT;
  localparam logic [XLEN-1:0] IH_M    = XLEN'(1) << IH_BIT;
  localparam logic [XLEN-1:0] DBL_M   = XLEN'(1) << DBL_BIT;
  localparam logic [XLEN-1:0] WR_M    = XLEN'(1) << WR_BIT;
  localparam logic [XLEN-1:0] CAUSE_M = ((XLEN'(1) << CAUSE_W) - XLEN'(1)) << CAUSE_LSB;

  logic [XLEN-1:0] retAddr, causeField, statusCalc, excCalc, tlbCalc;

  always_comb begin
    retAddr    = curPc + XLEN'(4);
    causeField = XLEN'(excCause) << CAUSE_LSB;
    statusCalc = (curStatus | (strobes.useIh ? IH_M : EH_M)) & ~(PIE_M | U_M);
    excCalc    = strobes.excFull ? causeField : ((curExcReg & ~CAUSE_M) | causeField);
    tlbCalc    = strobes.tlbDbl ? (curTlbMisc | DBL_M) : ((curTlbMisc & ~DBL_M) | WR_M);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      statusWe <= 1'b0; estatusWe <= 1'b0; bstatusWe <= 1'b0; excRegWe <= 1'b0;
      eaWe <= 1'b0; baWe <= 1'b0; tlbMiscWe <= 1'b0; badAddrWe <= 1'b0;
      pcWe <= 1'b0; unhandledErr <= 1'b0;
      nextStatus <= '0; nextEstatus <= '0; nextBstatus <= '0; nextExcReg <= '0;
      nextEa <= '0; nextBa <= '0; nextTlbMisc <= '0; nextBadAddr <= '0; nextPc <= '0;
    end else begin
      statusWe     <= strobes.taken;
      excRegWe     <= strobes.taken;
      pcWe         <= strobes.taken;
      estatusWe    <= strobes.saveE;
      eaWe         <= strobes.saveE;
      bstatusWe    <= strobes.saveB;
      baWe         <= strobes.saveB;
      tlbMiscWe    <= strobes.tlbTouch;
      badAddrWe    <= strobes.loadBad;
      unhandledErr <= strobes.bad;
      if (strobes.taken) begin
        nextStatus <= statusCalc;
        nextExcReg <= excCalc;
        nextPc     <= strobes.fastVec ? XLEN'(FAST_VEC) : XLEN'(GEN_VEC);
      end
      if (strobes.saveE) begin
        nextEstatus <= curStatus;
        nextEa      <= retAddr;
      end
      if (strobes.saveB) begin
        nextBstatus <= curStatus;
        nextBa      <= retAddr;
      end
      if (strobes.tlbTouch) nextTlbMisc <= tlbCalc;
      if (strobes.loadBad)  nextBadAddr <= faultAddr;
    end
  end

  p_status_clear_r1: assert property (@(posedge clk) disable iff (!rstN)
    statusWe |-> (!nextStatus[PIE_BIT] && !nextStatus[U_BIT] &&
                  (nextStatus[EH_BIT] || nextStatus[IH_BIT])));

  p_ea_pair_r3: assert property (@(posedge clk) disable iff (!rstN)
    estatusWe |-> (eaWe && statusWe));

  p_double_nosave_r5: assert property (@(posedge clk) disable iff (!rstN)
    (tlbMiscWe && nextTlbMisc[DBL_BIT]) |-> (!estatusWe && !eaWe && nextPc == XLEN'(GEN_VEC)));

  p_unhandled_quiet_r10: assert property (@(posedge clk) disable iff (!rstN)
    unhandledErr |-> (!statusWe && !pcWe && !eaWe && !baWe && !tlbMiscWe));

  p_pulse_src_r11: assert property (@(posedge clk) disable iff (!rstN)
    (statusWe || unhandledErr) |-> $past(excValid));

endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
  import exc_entry_pkg::*;
#(
  parameter int          XLEN     = 32,
  parameter int          CAUSE_W  = 5,
  parameter int          EH_BIT   = 2,
  parameter logic [31:0] GEN_VEC  = 32'h0000_0020,
  parameter logic [31:0] FAST_VEC = 32'h0000_0100
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               excValid,
  input  logic [CAUSE_W-1:0] excCause,
  input  logic [XLEN-1:0]    curPc,
  input  logic [XLEN-1:0]    curStatus,
  input  logic [XLEN-1:0]    curExcReg,
  input  logic [XLEN-1:0]    curTlbMisc,
  input  logic [XLEN-1:0]    faultAddr,
  output logic               statusWe,
  output logic [XLEN-1:0]    nextStatus,
  output logic               estatusWe,
  output logic [XLEN-1:0]    nextEstatus,
  output logic               bstatusWe,
  output logic [XLEN-1:0]    nextBstatus,
  output logic               excRegWe,
  output logic [XLEN-1:0]    nextExcReg,
  output logic               eaWe,
  output logic [XLEN-1:0]    nextEa,
  output logic               baWe,
  output logic [XLEN-1:0]    nextBa,
  output logic               tlbMiscWe,
  output logic [XLEN-1:0]    nextTlbMisc,
  output logic               badAddrWe,
  output logic [XLEN-1:0]    nextBadAddr,
  output logic               pcWe,
  output logic [XLEN-1:0]    nextPc,
  output logic               unhandledErr
);

  exc_strobe_t strobes;

  exc_entry_ctrl #(.CAUSE_W(CAUSE_W)) u_ctrl (
    .excValid(excValid), .excCause(excCause), .ehIn(curStatus[EH_BIT]),
    .strobes(strobes)
  );

  exc_entry_dp #(
    .XLEN(XLEN), .CAUSE_W(CAUSE_W), .EH_BIT(EH_BIT),
    .GEN_VEC(GEN_VEC), .FAST_VEC(FAST_VEC)
  ) u_dp (
    .clk(clk), .rstN(rstN), .excValid(excValid), .strobes(strobes),
    .excCause(excCause), .curPc(curPc), .curStatus(curStatus),
    .curExcReg(curExcReg), .curTlbMisc(curTlbMisc), .faultAddr(faultAddr),
    .statusWe(statusWe), .nextStatus(nextStatus),
    .estatusWe(estatusWe), .nextEstatus(nextEstatus),
    .bstatusWe(bstatusWe), .nextBstatus(nextBstatus),
    .excRegWe(excRegWe), .nextExcReg(nextExcReg),
    .eaWe(eaWe), .nextEa(nextEa), .baWe(baWe), .nextBa(nextBa),
    .tlbMiscWe(tlbMiscWe), .nextTlbMisc(nextTlbMisc),
    .badAddrWe(badAddrWe), .nextBadAddr(nextBadAddr),
    .pcWe(pcWe), .nextPc(nextPc), .unhandledErr(unhandledErr)
  );

endmodule

// File: tb/sim_exc_entry_seq.sv
module sim_exc_entry_seq;

  localparam logic [31:0] GV = 32'hC000_0120;
  localparam logic [31:0] FV = 32'hC000_0240;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic excValid = 1'b0;
  logic [4:0] excCause = '0;
  logic [31:0] curPc = '0, curStatus = '0, curExcReg = '0, curTlbMisc = '0, faultAddr = '0;
  logic statusWe, estatusWe, bstatusWe, excRegWe, eaWe, baWe, tlbMiscWe, badAddrWe, pcWe, unhandledErr;
  logic [31:0] nextStatus, nextEstatus, nextBstatus, nextExcReg, nextEa, nextBa;
  logic [31:0] nextTlbMisc, nextBadAddr, nextPc;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  exc_entry_seq #(.GEN_VEC(GV), .FAST_VEC(FV)) u0 (
    .clk(clk), .rstN(rstN), .excValid(excValid), .excCause(excCause),
    .curPc(curPc), .curStatus(curStatus), .curExcReg(curExcReg),
    .curTlbMisc(curTlbMisc), .faultAddr(faultAddr),
    .statusWe(statusWe), .nextStatus(nextStatus),
    .estatusWe(estatusWe), .nextEstatus(nextEstatus),
    .bstatusWe(bstatusWe), .nextBstatus(nextBstatus),
    .excRegWe(excRegWe), .nextExcReg(nextExcReg),
    .eaWe(eaWe), .nextEa(nextEa), .baWe(baWe), .nextBa(nextBa),
    .tlbMiscWe(tlbMiscWe), .nextTlbMisc(nextTlbMisc),
    .badAddrWe(badAddrWe), .nextBadAddr(nextBadAddr),
    .pcWe(pcWe), .nextPc(nextPc), .unhandledErr(unhandledErr)
  );

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s cause=%0d eh=%0d: actual %h expected %h",
               req, what, excCause, curStatus[2], act, exp);
    end
  endtask

  task automatic runCase(input int c, input int eh, input int pat);
    bit isIrq, isMiss, isPerm, isFault, isBrk, isAl, taken;
    bit expE, expB;
    string tag;
    logic [31:0] st, ex, tl, pc, fa, expSt, expEx, expTl, expPc;
    st = (pat == 0) ? 32'h0000_0003 : (pat == 1) ? 32'hFFFF_FFFB : 32'h5A5A_1230;
    st[2] = eh[0];
    ex = (pat == 0) ? 32'h0 : (pat == 1) ? 32'hFFFF_FFFF : 32'h8000_0101;
    tl = (pat == 0) ? 32'h0000_0008 : (pat == 1) ? 32'hFFFB_FFF7 : 32'h1234_0000;
    pc = 32'h0000_1000 + 32'(pat * 32'h111C) + 32'(c * 4);
    fa = 32'hDEAD_0001 + 32'(c);
    isIrq = (c == 2); isMiss = (c == 12); isPerm = (c >= 13 && c <= 15);
    isFault = (c == 3 || c == 5 || c == 9 || c == 10 || c == 11);
    isBrk = (c == 1); isAl = (c == 6);
    taken = isIrq | isMiss | isPerm | isFault | isBrk | isAl;
    expE = isIrq | isPerm | ((isMiss | isFault | isAl) & (eh == 0));
    expB = isBrk & (eh == 0);
    expSt = (st | (isIrq ? 32'h8 : 32'h4)) & ~32'h3;
    expEx = isAl ? (32'(c) << 2) : ((ex & ~32'h7C) | (32'(c) << 2));
    expTl = (eh != 0) ? (tl | 32'h8) : ((tl & ~32'h8) | 32'h0004_0000);
    expPc = (isMiss && eh == 0) ? FV : GV;
    tag = isIrq ? "R3" : isMiss ? ((eh != 0) ? "R5" : "R4") : isPerm ? "R6" :
          isFault ? "R7" : isBrk ? "R8" : isAl ? "R9" : "R10";

    @(negedge clk);
    excValid = 1'b1; excCause = 5'(c); curStatus = st; curExcReg = ex;
    curTlbMisc = tl; curPc = pc; faultAddr = fa;
    @(negedge clk);
    excValid = 1'b0;
    check(tag, "unhandledErr", 32'(unhandledErr), 32'(!taken));
    check("R1", "statusWe", 32'(statusWe), 32'(taken));
    check(tag, "pcWe", 32'(pcWe), 32'(taken));
    check(tag, "estatusWe", 32'(estatusWe), 32'(expE));
    check(tag, "eaWe", 32'(eaWe), 32'(expE));
    check(tag, "bstatusWe", 32'(bstatusWe), 32'(expB));
    check(tag, "baWe", 32'(baWe), 32'(expB));
    check(tag, "tlbMiscWe", 32'(tlbMiscWe), 32'(isMiss));
    check("R9", "badAddrWe", 32'(badAddrWe), 32'(isAl));
    if (taken) begin
      check("R1", "nextStatus", nextStatus, expSt);
      check(isAl ? "R9" : "R2", "nextExcReg", nextExcReg, expEx);
      check(tag, "nextPc", nextPc, expPc);
    end
    if (expE) begin
      check(tag, "nextEstatus", nextEstatus, st);
      check(tag, "nextEa", nextEa, pc + 32'd4);
    end
    if (expB) begin
      check("R8", "nextBstatus", nextBstatus, st);
      check("R8", "nextBa", nextBa, pc + 32'd4);
    end
    if (isMiss) check(tag, "nextTlbMisc", nextTlbMisc, expTl);
    if (isAl) check("R9", "nextBadAddr", nextBadAddr, fa);
    @(negedge clk);
    // R11: pulses last one cycle only
    check("R11", "pulse after idle", 32'({statusWe, estatusWe, bstatusWe, eaWe, baWe,
          tlbMiscWe, badAddrWe, pcWe, excRegWe, unhandledErr}), 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R11", "enables in reset", 32'({statusWe, pcWe, eaWe, unhandledErr}), 32'h0);
    rstN = 1'b1;
    @(negedge clk);
    check("R11", "enables after reset", 32'({statusWe, pcWe, eaWe, baWe, unhandledErr}), 32'h0);
    for (int c = 0; c < 32; c++)
      for (int eh = 0; eh < 2; eh++)
        for (int pat = 0; pat < 3; pat++)
          runCase(c, eh, pat);
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL R11 watchdog expired: actual hung expected done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule